// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Sequencer

This block sits beside the control unit of an 8-bit CPU core that uses three maskable-interrupt modes. On every clock it decides whether a pending maskable request may be taken. If it may, the block runs the acknowledge response one T-state per clock. It emits the single-cycle strobes that update the core's state: the interrupt enable flip-flops, the refresh counter, the parity/overflow flag, the halt latch, the program counter, the stack pointer and MEMPTR. It also emits the memory write and read requests that push the return address and fetch a vectored target.

Mode 1 always jumps to 0x0038 after 13 T-states. Mode 2 builds a table address from the I register and a byte read from the data bus, and loads the new program counter from that table after 19 T-states. Mode 0 only passes the acknowledge byte to the core's instruction decoder. It then waits until the decoder reports that the instruction, including any prefix bytes, has completed. The length of that instruction becomes the cycle count.

The parity-flag quirk of the older NMOS process is chosen by a parameter. A companion decoder supplies `im0_done` and the memory system supplies `mem_rdata` in the same cycle as `mem_rd`.

Top module: `irq_accept_seq`

## Requirements
- R1: A response starts on a clock edge only when all of the following hold at that edge: the sequencer is idle, `int_req`=1, `iff1`=1, `op_busy`=0, `prefix_pend`=0 and `ei_shadow`=0. While no response runs, every output is 0, `tstates` included.
- R2: The cycle after the starting edge is T-state 1. In T-state 1, `iff_clr` and `mark_clr` pulse for exactly that one cycle.
- R3: If `halted` was 1 at the starting edge, T-state 1 also pulses `halt_clr` and `pc_wr`, with `pc_wdata` equal to the sampled PC plus 1. That incremented value is the PC the response uses and pushes.
- R4: With parameter NMOS_PV=1, `pv_clr` pulses in T-state 1 exactly when `ldair_mark` was 1 at the starting edge. With NMOS_PV=0, `pv_clr` never pulses.
- R5: Mode 1 (`im_mode`=1) pulses `r_inc` in T-state 1. In T-state 7 it writes the PC high byte to SP-1. In T-state 10 it writes the PC low byte to SP-2, together with `sp_wr` and `sp_wdata`=SP-2. In T-state 13 it asserts `done` with `tstates`=13 and `pc_wr` with 0x0038. I and the bus byte have no effect.
- R6: Mode 2 (`im_mode`=2) samples `ack_data` at the end of T-state 3 as the vector byte V. It reads address {I,V} in T-state 13 and the 16-bit incremented address {I,V}+1 in T-state 16. It takes `mem_rdata` as the new PC low byte and high byte respectively.
- R7: Mode 2 pulses `r_inc` in T-state 1 and pushes the PC exactly as in R5. In T-state 19 it asserts `done` with `tstates`=19, and `pc_wr` and `memptr_wr` both carry the PC read from the table.
- R8: Modes 0 and 3 pulse `im0_exec` in T-state 1, with `im0_byte` equal to `ack_data` as sampled at the starting edge. There is no `r_inc`, push or read. `done` is asserted in the first cycle from T-state 1 on in which `im0_done`=1, and `tstates` then equals that T-state number.
- R9: `vec_req` is 1 from T-state 1 through the `done` cycle inclusive. No new response starts before the cycle after `done`.
- R10: `im_mode`, `i_reg`, `pc_cur`, `sp_cur`, `halted` and `ldair_mark` are sampled only at the starting edge. Later changes to them have no effect on the running response.
- R11: `mem_wr` and `mem_rd` are never both 1. `pc_wdata`, `sp_wdata`, `mem_addr`, `mem_wdata`, `memptr`, `im0_byte` and `tstates` read 0 whenever the strobe they belong to is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 1 | Maskable interrupt request level |
| iff1 | input | 1 | Interrupt enable flip-flop 1 |
| op_busy | input | 1 | An opcode is executing |
| prefix_pend | input | 1 | A prefix byte has been fetched, opcode not yet complete |
| ei_shadow | input | 1 | One-instruction shadow after enable-interrupts |
| halted | input | 1 | Core is in the halt state |
| ldair_mark | input | 1 | Last instruction copied IFF2 into the parity flag |
| im_mode | input | 2 | Interrupt mode, 0 to 3 |
| i_reg | input | 8 | Interrupt page register |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 16 | Current stack pointer |
| ack_data | input | 8 | Data bus byte during acknowledge |
| mem_rdata | input | 8 | Read data for `mem_rd`, same cycle |
| im0_done | input | 1 | Decoder has finished the mode-0 instruction |
| iff_clr | output | 1 | Clear IFF1 and IFF2 |
| pv_clr | output | 1 | Clear the parity/overflow flag |
| mark_clr | output | 1 | Clear the ldair marker |
| halt_clr | output | 1 | Leave the halt state |
| r_inc | output | 1 | Increment the refresh register |
| pc_wr | output | 1 | Load the program counter |
| pc_wdata | output | 16 | New program counter |
| sp_wr | output | 1 | Load the stack pointer |
| sp_wdata | output | 16 | New stack pointer |
| mem_wr | output | 1 | Memory write request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| memptr_wr | output | 1 | Load MEMPTR |
| memptr | output | 16 | New MEMPTR value |
| im0_exec | output | 1 | Hand the acknowledge byte to the decoder |
| im0_byte | output | 8 | Byte to execute in mode 0 |
| vec_req | output | 1 | Acknowledge sequence in progress |
| done | output | 1 | Last cycle of the response |
| tstates | output | 6 | T-states used, valid with `done` |

## Verification
Four properties are checked on every cycle. No response begins without the full acceptance condition. `vec_req` stays high until `done`. The enable-clear strobe never lasts two cycles. The T-state counter advances by one per cycle. Other per-cycle properties tie the halt exit to a PC load, keep reads and writes apart, and keep MEMPTR and a nonzero count tied to `done`.

The exact cycle of each push, the table addresses and their carry across the page boundary, the data returned into the new PC, the mode-0 length, and the insensitivity to inputs changed mid-response can only be shown by the bench. It compares every output on every T-state of each response against a model, under directed corner cases and seeded random responses.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    // T-state positions of the vectored responses
    localparam int T_VEC_SAMPLE = 3;
    localparam int T_PUSH_HI    = 7;
    localparam int T_PUSH_LO    = 10;
    localparam int T_TBL_LO     = 13;
    localparam int T_TBL_HI     = 16;
    localparam int T_END_FIXED  = 13;
    localparam int T_END_TABLE  = 19;

    localparam logic [ADDR_W-1:0] FIXED_TARGET = 16'h0038;

    typedef enum logic [1:0] {
        IM_EXEC  = 2'd0,
        IM_FIXED = 2'd1,
        IM_TABLE = 2'd2,
        IM_EXEC3 = 2'd3
    } im_e;

    typedef struct packed {
        im_e               mode;
        logic [BYTE_W-1:0] page;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic              was_halted;
        logic              pv_hit;
        logic [BYTE_W-1:0] op_byte;
    } ctx_t;

    function automatic logic is_vectored(im_e m);
        return (m == IM_FIXED) || (m == IM_TABLE);
    endfunction

    function automatic int end_tstate(im_e m);
        return (m == IM_TABLE) ? T_END_TABLE : T_END_FIXED;
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate (
    input  logic run,
    input  logic int_req,
    input  logic iff1,
    input  logic op_busy,
    input  logic prefix_pend,
    input  logic ei_shadow,
    output logic start
);
    always_comb begin
        start = !run && int_req && iff1 && !op_busy && !prefix_pend && !ei_shadow;
    end
endmodule

// File: rtl/irq_tstate_ctr.sv
module irq_tstate_ctr #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          finish,
    output logic          run,
    output logic [TW-1:0] tcnt
);
    localparam logic [TW-1:0] TMAX = '1;
    localparam logic [TW-1:0] TONE = TW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            tcnt <= '0;
        end else if (!run) begin
            if (start) begin
                run  <= 1'b1;
                tcnt <= TONE;
            end
        end else if (finish) begin
            run  <= 1'b0;
            tcnt <= '0;
        end else if (tcnt != TMAX) begin
            tcnt <= tcnt + TONE;
        end
    end

    // R9: one T-state per clock while the response runs
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && !finish && tcnt != TMAX) |=> (run && tcnt == $past(tcnt) + TONE));

    // R2: a fresh response always begins in T-state 1
    a_r2_first_tstate: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (tcnt == TONE));
endmodule

// File: rtl/irq_ctx_latch.sv
module irq_ctx_latch
    import irq_seq_pkg::*;
#(
    parameter int TW      = 6,
    parameter bit NMOS_PV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [TW-1:0]     tcnt,
    input  logic [1:0]        im_mode,
    input  logic [BYTE_W-1:0] i_reg,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] sp_cur,
    input  logic              halted,
    input  logic              ldair_mark,
    input  logic [BYTE_W-1:0] ack_data,
    input  logic [BYTE_W-1:0] mem_rdata,
    output ctx_t              ctx,
    output logic [BYTE_W-1:0] vec,
    output logic [BYTE_W-1:0] tbl_lo,
    output logic [BYTE_W-1:0] tbl_hi
);
    logic pv_src;

    generate
        if (NMOS_PV) begin : g_nmos
            assign pv_src = ldair_mark;
        end else begin : g_cmos
            assign pv_src = 1'b0;
        end
    endgenerate

    logic table_mode;
    assign table_mode = run && (ctx.mode == IM_TABLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx    <= '0;
            vec    <= '0;
            tbl_lo <= '0;
            tbl_hi <= '0;
        end else begin
            if (start) begin
                ctx.mode       <= im_e'(im_mode);
                ctx.page       <= i_reg;
                ctx.pc         <= halted ? pc_cur + 16'd1 : pc_cur;
                ctx.sp         <= sp_cur;
                ctx.was_halted <= halted;
                ctx.pv_hit     <= pv_src;
                ctx.op_byte    <= ack_data;
            end
            if (table_mode && tcnt == TW'(T_VEC_SAMPLE)) vec    <= ack_data;
            if (table_mode && tcnt == TW'(T_TBL_LO))     tbl_lo <= mem_rdata;
            if (table_mode && tcnt == TW'(T_TBL_HI))     tbl_hi <= mem_rdata;
        end
    end
endmodule

// File: rtl/irq_strobe_dec.sv
module irq_strobe_dec
    import irq_seq_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic              run,
    input  logic [TW-1:0]     tcnt,
    input  ctx_t              ctx,
    input  logic [BYTE_W-1:0] vec,
    input  logic [BYTE_W-1:0] tbl_lo,
    input  logic [BYTE_W-1:0] tbl_hi,
    input  logic              im0_done,
    output logic              iff_clr,
    output logic              pv_clr,
    output logic              mark_clr,
    output logic              halt_clr,
    output logic              r_inc,
    output logic              pc_wr,
    output logic [ADDR_W-1:0] pc_wdata,
    output logic              sp_wr,
    output logic [ADDR_W-1:0] sp_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              memptr_wr,
    output logic [ADDR_W-1:0] memptr,
    output logic              im0_exec,
    output logic [BYTE_W-1:0] im0_byte,
    output logic              vec_req,
    output logic              done,
    output logic [TW-1:0]     tstates
);
    logic              vect;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] new_pc;

    always_comb begin
        vect     = is_vectored(ctx.mode);
        tbl_addr = {ctx.page, vec};
        new_pc   = (ctx.mode == IM_FIXED) ? FIXED_TARGET : {tbl_hi, tbl_lo};

        iff_clr = 1'b0; pv_clr = 1'b0; mark_clr = 1'b0; halt_clr = 1'b0;
        r_inc = 1'b0; pc_wr = 1'b0; pc_wdata = '0; sp_wr = 1'b0; sp_wdata = '0;
        mem_wr = 1'b0; mem_rd = 1'b0; mem_addr = '0; mem_wdata = '0;
        memptr_wr = 1'b0; memptr = '0; im0_exec = 1'b0; im0_byte = '0;
        vec_req = 1'b0; done = 1'b0; tstates = '0;

        if (run) begin
            vec_req = 1'b1;
            if (tcnt == TW'(1)) begin
                iff_clr  = 1'b1;
                mark_clr = 1'b1;
                pv_clr   = ctx.pv_hit;
                if (ctx.was_halted) begin
                    halt_clr = 1'b1;
                    pc_wr    = 1'b1;
                    pc_wdata = ctx.pc;
                end
                if (vect) begin
                    r_inc = 1'b1;
                end else begin
                    im0_exec = 1'b1;
                    im0_byte = ctx.op_byte;
                end
            end
            if (vect) begin
                if (tcnt == TW'(T_PUSH_HI)) begin
                    mem_wr    = 1'b1;
                    mem_addr  = ctx.sp - 16'd1;
                    mem_wdata = ctx.pc[15:8];
                end
                if (tcnt == TW'(T_PUSH_LO)) begin
                    mem_wr    = 1'b1;
                    mem_addr  = ctx.sp - 16'd2;
                    mem_wdata = ctx.pc[7:0];
                    sp_wr     = 1'b1;
                    sp_wdata  = ctx.sp - 16'd2;
                end
                if (ctx.mode == IM_TABLE && tcnt == TW'(T_TBL_LO)) begin
                    mem_rd   = 1'b1;
                    mem_addr = tbl_addr;
                end
                if (ctx.mode == IM_TABLE && tcnt == TW'(T_TBL_HI)) begin
                    mem_rd   = 1'b1;
                    mem_addr = tbl_addr + 16'd1;
                end
                if (tcnt == TW'(end_tstate(ctx.mode))) begin
                    done     = 1'b1;
                    pc_wr    = 1'b1;
                    pc_wdata = new_pc;
                    if (ctx.mode == IM_TABLE) begin
                        memptr_wr = 1'b1;
                        memptr    = new_pc;
                    end
                end
            end else if (im0_done) begin
                done = 1'b1;
            end
            if (done) tstates = tcnt;
        end
    end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int TW      = 6,   // must hold T_END_TABLE
    parameter bit NMOS_PV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_req,
    input  logic              iff1,
    input  logic              op_busy,
    input  logic              prefix_pend,
    input  logic              ei_shadow,
    input  logic              halted,
    input  logic              ldair_mark,
    input  logic [1:0]        im_mode,
    input  logic [7:0]        i_reg,
    input  logic [15:0]       pc_cur,
    input  logic [15:0]       sp_cur,
    input  logic [7:0]        ack_data,
    input  logic [7:0]        mem_rdata,
    input  logic              im0_done,
    output logic              iff_clr,
    output logic              pv_clr,
    output logic              mark_clr,
    output logic              halt_clr,
    output logic              r_inc,
    output logic              pc_wr,
    output logic [15:0]       pc_wdata,
    output logic              sp_wr,
    output logic [15:0]       sp_wdata,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              memptr_wr,
    output logic [15:0]       memptr,
    output logic              im0_exec,
    output logic [7:0]        im0_byte,
    output logic              vec_req,
    output logic              done,
    output logic [TW-1:0]     tstates
);
    logic              run;
    logic              start;
    logic [TW-1:0]     tcnt;
    ctx_t              ctx;
    logic [BYTE_W-1:0] vec;
    logic [BYTE_W-1:0] tbl_lo;
    logic [BYTE_W-1:0] tbl_hi;

    irq_gate u_gate (
        .run(run), .int_req(int_req), .iff1(iff1), .op_busy(op_busy),
        .prefix_pend(prefix_pend), .ei_shadow(ei_shadow), .start(start)
    );

    irq_tstate_ctr #(.TW(TW)) u_ctr (
        .clk(clk), .rst(rst), .start(start), .finish(done), .run(run), .tcnt(tcnt)
    );

    irq_ctx_latch #(.TW(TW), .NMOS_PV(NMOS_PV)) u_ctx (
        .clk(clk), .rst(rst), .start(start), .run(run), .tcnt(tcnt),
        .im_mode(im_mode), .i_reg(i_reg), .pc_cur(pc_cur), .sp_cur(sp_cur),
        .halted(halted), .ldair_mark(ldair_mark), .ack_data(ack_data),
        .mem_rdata(mem_rdata), .ctx(ctx), .vec(vec), .tbl_lo(tbl_lo), .tbl_hi(tbl_hi)
    );

    irq_strobe_dec #(.TW(TW)) u_dec (
        .run(run), .tcnt(tcnt), .ctx(ctx), .vec(vec), .tbl_lo(tbl_lo),
        .tbl_hi(tbl_hi), .im0_done(im0_done),
        .iff_clr(iff_clr), .pv_clr(pv_clr), .mark_clr(mark_clr), .halt_clr(halt_clr),
        .r_inc(r_inc), .pc_wr(pc_wr), .pc_wdata(pc_wdata), .sp_wr(sp_wr),
        .sp_wdata(sp_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .memptr_wr(memptr_wr), .memptr(memptr),
        .im0_exec(im0_exec), .im0_byte(im0_byte), .vec_req(vec_req),
        .done(done), .tstates(tstates)
    );

    // R1: a response only begins after a fully qualified request
    a_r1_start_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(int_req && iff1 && !op_busy && !prefix_pend && !ei_shadow));

    // R1: a nonzero count only appears together with done
    a_r1_count_with_done: assert property (@(posedge clk) disable iff (rst)
        (tstates != '0) |-> done);

    // R9: the vector request stays up until the response completes
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !done) |=> vec_req);

    // R2: the enable clear is a single-cycle pulse
    a_r2_iff_single: assert property (@(posedge clk) disable iff (rst)
        iff_clr |=> !iff_clr);

    // R3: leaving halt always comes with a PC load in the same T-state
    a_r3_halt_pc: assert property (@(posedge clk) disable iff (rst)
        halt_clr |-> (pc_wr && iff_clr));

    // R7: MEMPTR is only loaded in the final cycle
    a_r7_memptr_end: assert property (@(posedge clk) disable iff (rst)
        memptr_wr |-> done);

    // R11: a read and a write never share a cycle
    a_r11_bus_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr && mem_rd));
endmodule

// File: tb/irq_accept_seq_test.sv
module irq_accept_seq_test;
    localparam int CLK_NS = 10;
    localparam int TW     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic int_req = 0, iff1 = 0, op_busy = 0, prefix_pend = 0, ei_shadow = 0;
    logic halted = 0, ldair_mark = 0, im0_done = 0;
    logic [1:0]  im_mode = 0;
    logic [7:0]  i_reg = 0, ack_data = 0, mem_rdata;
    logic [15:0] pc_cur = 0, sp_cur = 0;

    logic iff_clr, pv_clr, mark_clr, halt_clr, r_inc, pc_wr, sp_wr;
    logic mem_wr, mem_rd, memptr_wr, im0_exec, vec_req, done;
    logic [15:0] pc_wdata, sp_wdata, mem_addr, memptr;
    logic [7:0]  mem_wdata, im0_byte;
    logic [TW-1:0] tstates;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    irq_accept_seq #(.TW(TW), .NMOS_PV(1'b1)) uut (.*);

    function automatic logic [7:0] tbl_byte(logic [15:0] a);
        return (a[7:0] + 8'(a[15:8] * 3)) ^ 8'h5A;
    endfunction

    always_comb mem_rdata = mem_rd ? tbl_byte(mem_addr) : 8'h00;

    typedef struct packed {
        logic iff_clr, pv_clr, mark_clr, halt_clr, r_inc, pc_wr;
        logic [15:0] pc_wdata;
        logic sp_wr;
        logic [15:0] sp_wdata;
        logic mem_wr, mem_rd;
        logic [15:0] mem_addr;
        logic [7:0] mem_wdata;
        logic memptr_wr;
        logic [15:0] memptr;
        logic im0_exec;
        logic [7:0] im0_byte;
        logic done;
        logic [TW-1:0] tstates;
        logic vec_req;
    } obs_t;

    function automatic obs_t observe();
        obs_t o;
        o = '{iff_clr, pv_clr, mark_clr, halt_clr, r_inc, pc_wr, pc_wdata, sp_wr,
              sp_wdata, mem_wr, mem_rd, mem_addr, mem_wdata, memptr_wr, memptr,
              im0_exec, im0_byte, done, tstates, vec_req};
        return o;
    endfunction

    // Model of every output in T-state t of a response
    function automatic obs_t expect_at(int t, int md, logic [7:0] ir, logic [15:0] pc,
                                       logic [15:0] sp, logic hl, logic ld,
                                       logic [7:0] bb, int n0);
        obs_t e = '0;
        logic [15:0] pp = hl ? pc + 16'd1 : pc;
        logic vect = (md == 1) || (md == 2);
        logic [15:0] ta = {ir, bb};
        e.vec_req = 1'b1;
        if (t == 1) begin
            e.iff_clr = 1; e.mark_clr = 1; e.pv_clr = ld;
            if (hl) begin e.halt_clr = 1; e.pc_wr = 1; e.pc_wdata = pp; end
            if (vect) e.r_inc = 1;
            else begin e.im0_exec = 1; e.im0_byte = bb; end
        end
        if (vect) begin
            if (t == 7)  begin e.mem_wr = 1; e.mem_addr = sp - 16'd1; e.mem_wdata = pp[15:8]; end
            if (t == 10) begin e.mem_wr = 1; e.mem_addr = sp - 16'd2; e.mem_wdata = pp[7:0];
                               e.sp_wr = 1; e.sp_wdata = sp - 16'd2; end
            if (md == 2 && t == 13) begin e.mem_rd = 1; e.mem_addr = ta; end
            if (md == 2 && t == 16) begin e.mem_rd = 1; e.mem_addr = ta + 16'd1; end
            if ((md == 1 && t == 13) || (md == 2 && t == 19)) begin
                e.done = 1; e.tstates = TW'(t); e.pc_wr = 1;
                e.pc_wdata = (md == 1) ? 16'h0038 : {tbl_byte(ta + 16'd1), tbl_byte(ta)};
                if (md == 2) begin e.memptr_wr = 1; e.memptr = e.pc_wdata; end
            end
        end else if (t == n0) begin
            e.done = 1; e.tstates = TW'(t);
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, obs_t act, obs_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(int t, int md, logic hl, logic ld, bit dn);
        if (dn) return (md == 2) ? "R7 done" : (md == 1) ? "R5 done" : "R8 done";
        if (t == 1) return hl ? "R3 halt exit" : ld ? "R4 pv clear" : "R2 first T-state";
        if (t == 7 || t == 10) return "R5 push";
        if (md == 2 && (t == 13 || t == 16)) return "R6 table read";
        return "R9 R11 idle T-state";
    endfunction

    task automatic run_irq(int md, logic [7:0] ir, logic [15:0] pc, logic [15:0] sp,
                           logic hl, logic ld, logic [7:0] bb, int n0);
        obs_t e, a;
        bit ended = 0;
        @(negedge clk);
        int_req = 1; iff1 = 1; op_busy = 0; prefix_pend = 0; ei_shadow = 0;
        im_mode = 2'(md); i_reg = ir; pc_cur = pc; sp_cur = sp; halted = hl;
        ldair_mark = ld; ack_data = bb; im0_done = 0;
        @(posedge clk);
        for (int t = 1; t <= 40 && !ended; t++) begin
            @(negedge clk);
            if (t >= 4) begin
                // R10: scramble the sampled inputs after the vector byte is taken
                im_mode = 2'($urandom); i_reg = 8'($urandom); pc_cur = 16'($urandom);
                sp_cur = 16'($urandom); halted = 1'($urandom); ldair_mark = 1'($urandom);
                ack_data = 8'($urandom);
            end
            if (!(md == 1 || md == 2) && t == n0) im0_done = 1;
            #1;
            e = expect_at(t, md, ir, pc, sp, hl, ld, bb, n0);
            a = observe();
            check(a == e, tag_for(t, md, hl, ld, e.done), a, e);
            if (e.done) begin ended = 1; int_req = 0; end
        end
        @(negedge clk);
        im0_done = 0; halted = 0; ldair_mark = 0;
        #1;
        a = observe();
        check(a == '0, "R9 idle after done", a, '0);
    endtask

    task automatic reject_case(int which);
        obs_t a;
        @(negedge clk);
        int_req = 1; iff1 = 1; op_busy = 0; prefix_pend = 0; ei_shadow = 0;
        case (which)
            0: iff1 = 0;
            1: op_busy = 1;
            2: prefix_pend = 1;
            3: ei_shadow = 1;
            default: int_req = 0;
        endcase
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            a = observe();
            check(a == '0, "R1 R11 blocked request", a, '0);
        end
        int_req = 0; op_busy = 0; prefix_pend = 0; ei_shadow = 0;
    endtask

    initial begin
        obs_t a;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        #1;
        a = observe();
        check(a == '0, "R1 reset state", a, '0);
        @(negedge clk);
        rst = 0;

        for (int w = 0; w < 5; w++) reject_case(w);

        run_irq(1, 8'h77, 16'h1234, 16'h8000, 0, 0, 8'hEE, 0);  // R5 fixed target
        run_irq(2, 8'h3F, 16'hABCD, 16'hC000, 0, 1, 8'hFF, 0);  // R6 page carry, R4
        run_irq(2, 8'h10, 16'h00FF, 16'h0001, 1, 0, 8'h20, 0);  // R3 halt, SP wrap
        run_irq(1, 8'h00, 16'hFFFF, 16'h0000, 1, 1, 8'h00, 0);  // R3 PC wrap
        run_irq(0, 8'h55, 16'h4000, 16'h9000, 0, 0, 8'hCB, 4);  // R8 mode 0
        run_irq(3, 8'h55, 16'h4000, 16'h9000, 1, 1, 8'hDD, 23); // R8 mode 3, long prefixed
        run_irq(0, 8'h01, 16'h0100, 16'h0200, 0, 0, 8'hC7, 1);  // R8 one-state edge

        for (int n = 0; n < 40; n++) begin
            if (n % 8 == 3) reject_case(int'($urandom_range(0, 4)));
            run_irq(int'($urandom_range(0, 3)), 8'($urandom), 16'($urandom), 16'($urandom),
                    1'($urandom), 1'($urandom), 8'($urandom), int'($urandom_range(1, 20)));
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule